// File: doc/BRIEF.md
# Serial Configuration Port for a Triple-Loop Frequency Synthesizer

This block is the control front end of a synthesizer with one IF loop and two RF loops. A host writes 22-bit words over three wires: a serial clock, a serial data line and an active-low enable. Each word holds an 18-bit data field and a 4-bit address. The port shifts bits in on serial-clock rising edges while the enable is low. When the enable rises, it commits the data field to the register that the address selects.

All three serial wires are sampled by the block's own system clock, through a synchronizer, and their edges are found on that clock. The register contents feed the rest of the chip:
- the three loop divider values;
- which RF loop drives the shared RF output;
- the IF low-power flag;
- IF, RF and reference-amplifier power enables, combined with an active-low hardware power-down pin;
- an auxiliary output that is either held low or carries an out-of-lock indicator.

Top module: `synth_cfg_port`

## Requirements
- R1: A word is 22 bits long. The first bit shifted in is data bit 17 and the last is address bit 0, so the data field occupies word bits 21:4 and the address occupies word bits 3:0. When the enable rises, the data field is stored in the addressed register.
- R2: Only the most recent 22 bits shifted before the enable rises are used. Any earlier bits in the same enable-low window are discarded.
- R3: Serial-clock edges while the enable is high shift nothing. An enable low-then-high pulse with no clock edges re-commits the word that was already held.
- R4: Address 0 is the main configuration. Bits 13:12 are the aux select code, bit 5 is the IF low-power flag (it drives `if_low_pwr`), and bit 3 is the auto power-up bit.
- R5: Address 2 holds the power bits: bit 1 is the IF enable and bit 0 is the RF enable.
- R6: Address 3 loads the 18-bit RF1 divider, address 4 the 17-bit RF2 divider and address 5 the 16-bit IF divider. Each divider takes the low-order data bits; data bits above its width are dropped.
- R7: `rf2_sel` is 0 after a write to address 3 and 1 after a write to address 4. Writes to other addresses leave it unchanged.
- R8: While `pwr_dn_n` is 0, `if_on` and `rf_on` are both 0, whatever the registers hold.
- R9: While `pwr_dn_n` is 1, the auto bit set to 1 turns both `if_on` and `rf_on` on. With the auto bit at 0, `if_on` follows the IF enable bit and `rf_on` follows the RF enable bit.
- R10: `ref_on` is 1 exactly when `if_on` or `rf_on` is 1.
- R11: `aux_out` follows `lock_lost` when the aux select code is 2'b11. It is 0 for codes 2'b01, 2'b00 and 2'b10.
- R12: Writes to address 1 and to addresses 6 through 15 change no output.
- R13: Reset clears every register. After reset the dividers are zero, `rf2_sel` is 0, `if_low_pwr`, `if_on`, `rf_on` and `ref_on` are 0, and `aux_out` is 0.
- R14: Words written while `pwr_dn_n` is 0 are committed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB of the data field first |
| ser_en_n | input | 1 | Active-low serial enable; its rising edge commits the word |
| pwr_dn_n | input | 1 | Active-low hardware power-down |
| lock_lost | input | 1 | Active-high out-of-lock indicator from the loops |
| div_rf1 | output | 18 | RF1 loop divider value |
| div_rf2 | output | 17 | RF2 loop divider value |
| div_if | output | 16 | IF loop divider value |
| rf2_sel | output | 1 | 1 selects the RF2 loop, 0 selects RF1 |
| if_on | output | 1 | IF loop powered |
| rf_on | output | 1 | RF loop powered |
| ref_on | output | 1 | Reference amplifier powered |
| if_low_pwr | output | 1 | IF output amplifier low-bias mode |
| aux_out | output | 1 | Auxiliary output |

## Verification
The bench builds the block with its default parameters: 18-bit data, the three divider widths 18, 17 and 16, and a two-stage synchronizer. With these widths the data field fills the RF1 divider exactly, while the RF2 and IF dividers must drop their top bits, so the all-ones and truncation cases are reachable. The two-stage synchronizer sets the commit latency that the bench waits out after each enable rise. Random words use all sixteen addresses and vary the number of leading surplus bits, the power-down pin and the lock indicator, which covers discarded prefixes and reserved-address writes under every power state.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int ADDR_W      = 4;
    localparam int DEF_DATA_W  = 18;
    localparam int DEF_RF1_W   = 18;
    localparam int DEF_RF2_W   = 17;
    localparam int DEF_IF_W    = 16;

    // field positions inside the main configuration word
    localparam int MAIN_AUX_LSB  = 12;
    localparam int MAIN_LOWP_BIT = 5;
    localparam int MAIN_AUTO_BIT = 3;
    // field positions inside the power word
    localparam int PWR_IF_BIT    = 1;
    localparam int PWR_RF_BIT    = 0;

    typedef enum logic [1:0] {
        AUX_RSV0 = 2'b00,
        AUX_LOW  = 2'b01,
        AUX_RSV2 = 2'b10,
        AUX_LOCK = 2'b11
    } aux_sel_e;

    typedef enum logic {
        BAND_RF1 = 1'b0,
        BAND_RF2 = 1'b1
    } band_e;

    typedef struct packed {
        aux_sel_e aux_sel;
        logic     if_low_pwr;
        logic     auto_up;
    } main_cfg_t;

    typedef struct packed {
        logic if_en;
        logic rf_en;
    } pwr_cfg_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_MAIN,
        TGT_PWR,
        TGT_RF1,
        TGT_RF2,
        TGT_IF
    } target_e;

    function automatic target_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            4'd0:    return TGT_MAIN;
            4'd2:    return TGT_PWR;
            4'd3:    return TGT_RF1;
            4'd4:    return TGT_RF2;
            4'd5:    return TGT_IF;
            default: return TGT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
    parameter int           STAGES  = 2,
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= RST_VAL;
                else     st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[i] <= RST_VAL;
                else     st[i] <= st[i-1];
            end
        end
    end

    assign q = st[STAGES-1];

endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift #(
    parameter int WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              sen_n_s,
    output logic [WORD_W-1:0] word,
    output logic              commit
);

    logic sclk_q;
    logic sen_n_q;
    logic sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign commit    = sen_n_s & ~sen_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sen_n_q <= 1'b1;
            word    <= '0;
        end else begin
            sclk_q  <= sclk_s;
            sen_n_q <= sen_n_s;
            if (sclk_rise && !sen_n_s)
                word <= {word[WORD_W-2:0], sdat_s};
        end
    end

endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
    import synth_cfg_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int RF1_W  = DEF_RF1_W,
    parameter int RF2_W  = DEF_RF2_W,
    parameter int IF_W   = DEF_IF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output main_cfg_t         main_cfg,
    output pwr_cfg_t          pwr_cfg,
    output logic [RF1_W-1:0]  div_rf1,
    output logic [RF2_W-1:0]  div_rf2,
    output logic [IF_W-1:0]   div_if,
    output band_e             band
);

    always_ff @(posedge clk) begin
        if (rst) begin
            main_cfg <= '{aux_sel: AUX_RSV0, if_low_pwr: 1'b0, auto_up: 1'b0};
            pwr_cfg  <= '0;
            div_rf1  <= '0;
            div_rf2  <= '0;
            div_if   <= '0;
            band     <= BAND_RF1;
        end else if (commit) begin
            case (decode_addr(addr))
                TGT_MAIN: begin
                    main_cfg.aux_sel    <= aux_sel_e'(data[MAIN_AUX_LSB +: 2]);
                    main_cfg.if_low_pwr <= data[MAIN_LOWP_BIT];
                    main_cfg.auto_up    <= data[MAIN_AUTO_BIT];
                end
                TGT_PWR: begin
                    pwr_cfg.if_en <= data[PWR_IF_BIT];
                    pwr_cfg.rf_en <= data[PWR_RF_BIT];
                end
                TGT_RF1: begin
                    div_rf1 <= data[RF1_W-1:0];
                    band    <= BAND_RF1;
                end
                TGT_RF2: begin
                    div_rf2 <= data[RF2_W-1:0];
                    band    <= BAND_RF2;
                end
                TGT_IF:  div_if <= data[IF_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/synth_cfg_power.sv
module synth_cfg_power
    import synth_cfg_pkg::*;
(
    input  logic      pwr_dn_n,
    input  logic      lock_lost,
    input  main_cfg_t main_cfg,
    input  pwr_cfg_t  pwr_cfg,
    output logic      if_on,
    output logic      rf_on,
    output logic      ref_on,
    output logic      aux_out
);

    always_comb begin
        if (!pwr_dn_n) begin
            if_on = 1'b0;
            rf_on = 1'b0;
        end else if (main_cfg.auto_up) begin
            if_on = 1'b1;
            rf_on = 1'b1;
        end else begin
            if_on = pwr_cfg.if_en;
            rf_on = pwr_cfg.rf_en;
        end
    end

    assign ref_on = if_on | rf_on;

    always_comb begin
        case (main_cfg.aux_sel)
            AUX_LOCK: aux_out = lock_lost;
            default:  aux_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int RF1_W       = DEF_RF1_W,
    parameter int RF2_W       = DEF_RF2_W,
    parameter int IF_W        = DEF_IF_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_en_n,
    input  logic             pwr_dn_n,
    input  logic             lock_lost,
    output logic [RF1_W-1:0] div_rf1,
    output logic [RF2_W-1:0] div_rf2,
    output logic [IF_W-1:0]  div_if,
    output logic             rf2_sel,
    output logic             if_on,
    output logic             rf_on,
    output logic             ref_on,
    output logic             if_low_pwr,
    output logic             aux_out
);

    localparam int WORD_W = DATA_W + ADDR_W;

    logic [2:0]        pins_s;
    logic [WORD_W-1:0] word;
    logic              commit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    main_cfg_t         main_cfg;
    pwr_cfg_t          pwr_cfg;
    band_e             band;

    synth_cfg_sync #(
        .STAGES (SYNC_STAGES),
        .W      (3),
        .RST_VAL(3'b100)
    ) sync_i (
        .clk(clk),
        .rst(rst),
        .d  ({ser_en_n, ser_clk, ser_dat}),
        .q  (pins_s)
    );

    synth_cfg_shift #(
        .WORD_W(WORD_W)
    ) shift_i (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (pins_s[1]),
        .sdat_s (pins_s[0]),
        .sen_n_s(pins_s[2]),
        .word   (word),
        .commit (commit)
    );

    assign addr = word[ADDR_W-1:0];
    assign data = word[WORD_W-1:ADDR_W];

    synth_cfg_regs #(
        .DATA_W(DATA_W),
        .RF1_W (RF1_W),
        .RF2_W (RF2_W),
        .IF_W  (IF_W)
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .addr    (addr),
        .data    (data),
        .main_cfg(main_cfg),
        .pwr_cfg (pwr_cfg),
        .div_rf1 (div_rf1),
        .div_rf2 (div_rf2),
        .div_if  (div_if),
        .band    (band)
    );

    synth_cfg_power power_i (
        .pwr_dn_n (pwr_dn_n),
        .lock_lost(lock_lost),
        .main_cfg (main_cfg),
        .pwr_cfg  (pwr_cfg),
        .if_on    (if_on),
        .rf_on    (rf_on),
        .ref_on   (ref_on),
        .aux_out  (aux_out)
    );

    assign rf2_sel    = (band == BAND_RF2);
    assign if_low_pwr = main_cfg.if_low_pwr;

endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk #(
    parameter int RF1_W = 18,
    parameter int RF2_W = 17,
    parameter int IF_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             pwr_dn_n,
    input logic             lock_lost,
    input logic             commit,
    input logic [3:0]       addr,
    input logic [1:0]       aux_sel,
    input logic             auto_up,
    input logic             if_en,
    input logic             rf_en,
    input logic [RF1_W-1:0] div_rf1,
    input logic [RF2_W-1:0] div_rf2,
    input logic [IF_W-1:0]  div_if,
    input logic             rf2_sel,
    input logic             if_on,
    input logic             rf_on,
    input logic             ref_on,
    input logic             if_low_pwr,
    input logic             aux_out
);

    assert_pin_off_R8: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |-> (!if_on && !rf_on));

    assert_auto_on_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_dn_n && auto_up) |-> (if_on && rf_on));

    assert_follow_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_dn_n && !auto_up) |-> (if_on == if_en && rf_on == rf_en));

    assert_ref_or_R10: assert property (@(posedge clk) disable iff (rst)
        ref_on == (if_on || rf_on));

    assert_aux_low_R11: assert property (@(posedge clk) disable iff (rst)
        (aux_sel != 2'b11) |-> !aux_out);

    assert_aux_lock_R11: assert property (@(posedge clk) disable iff (rst)
        (aux_sel == 2'b11) |-> (aux_out == lock_lost));

    assert_band_rf1_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == 4'd3) |=> !rf2_sel);

    assert_band_rf2_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == 4'd4) |=> rf2_sel);

    assert_reserved_R12: assert property (@(posedge clk) disable iff (rst)
        (commit && (addr == 4'd1 || addr >= 4'd6)) |=>
        ($stable(div_rf1) && $stable(div_rf2) && $stable(div_if) &&
         $stable(rf2_sel) && $stable(if_low_pwr) && $stable(aux_sel) &&
         $stable(auto_up) && $stable(if_en) && $stable(rf_en)));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(div_rf1) && $stable(div_rf2) && $stable(div_if)));

    assert_reset_R13: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (div_rf1 == '0 && div_rf2 == '0 && div_if == '0 &&
                        !rf2_sel && !if_low_pwr && !aux_out &&
                        !if_en && !rf_en && !auto_up));

endmodule

bind synth_cfg_port synth_cfg_chk #(
    .RF1_W(RF1_W),
    .RF2_W(RF2_W),
    .IF_W (IF_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pwr_dn_n  (pwr_dn_n),
    .lock_lost (lock_lost),
    .commit    (commit),
    .addr      (addr),
    .aux_sel   (main_cfg.aux_sel),
    .auto_up   (main_cfg.auto_up),
    .if_en     (pwr_cfg.if_en),
    .rf_en     (pwr_cfg.rf_en),
    .div_rf1   (div_rf1),
    .div_rf2   (div_rf2),
    .div_if    (div_if),
    .rf2_sel   (rf2_sel),
    .if_on     (if_on),
    .rf_on     (rf_on),
    .ref_on    (ref_on),
    .if_low_pwr(if_low_pwr),
    .aux_out   (aux_out)
);

// File: tb/synth_cfg_port_tb_top.sv
module synth_cfg_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en_n = 1'b1;
    logic        pwr_dn_n = 1'b1;
    logic        lock_lost = 1'b0;
    logic [17:0] div_rf1;
    logic [16:0] div_rf2;
    logic [15:0] div_if;
    logic        rf2_sel, if_on, rf_on, ref_on, if_low_pwr, aux_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model of the register contents
    logic [17:0] m_rf1;
    logic [16:0] m_rf2;
    logic [15:0] m_if;
    logic        m_band;
    logic [1:0]  m_aux;
    logic        m_lowp, m_auto, m_ifen, m_rfen;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_cfg_port dut_i (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_en_n(ser_en_n), .pwr_dn_n(pwr_dn_n), .lock_lost(lock_lost),
        .div_rf1(div_rf1), .div_rf2(div_rf2), .div_if(div_if),
        .rf2_sel(rf2_sel), .if_on(if_on), .rf_on(rf_on), .ref_on(ref_on),
        .if_low_pwr(if_low_pwr), .aux_out(aux_out)
    );

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        m_rf1 = '0; m_rf2 = '0; m_if = '0; m_band = 1'b0;
        m_aux = 2'b00; m_lowp = 1'b0; m_auto = 1'b0; m_ifen = 1'b0; m_rfen = 1'b0;
    endtask

    task automatic model_commit(input logic [3:0] a, input logic [17:0] d);
        case (a)
            4'd0: begin m_aux = d[13:12]; m_lowp = d[5]; m_auto = d[3]; end
            4'd2: begin m_ifen = d[1]; m_rfen = d[0]; end
            4'd3: begin m_rf1 = d; m_band = 1'b0; end
            4'd4: begin m_rf2 = d[16:0]; m_band = 1'b1; end
            4'd5: m_if = d[15:0];
            default: ;
        endcase
    endtask

    function automatic logic exp_if_on();
        return pwr_dn_n && (m_auto || m_ifen);
    endfunction

    function automatic logic exp_rf_on();
        return pwr_dn_n && (m_auto || m_rfen);
    endfunction

    function automatic logic exp_aux();
        return (m_aux == 2'b11) ? lock_lost : 1'b0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        string pw;
        pw = pwr_dn_n ? "R9" : "R8";
        chk("R6",  {ctx, " div_rf1"}, 32'(div_rf1), 32'(m_rf1));
        chk("R6",  {ctx, " div_rf2"}, 32'(div_rf2), 32'(m_rf2));
        chk("R6",  {ctx, " div_if"},  32'(div_if),  32'(m_if));
        chk("R7",  {ctx, " rf2_sel"}, 32'(rf2_sel), 32'(m_band));
        chk("R4",  {ctx, " if_low_pwr"}, 32'(if_low_pwr), 32'(m_lowp));
        chk(pw,    {ctx, " if_on"}, 32'(if_on), 32'(exp_if_on()));
        chk(pw,    {ctx, " rf_on"}, 32'(rf_on), 32'(exp_rf_on()));
        chk("R10", {ctx, " ref_on"}, 32'(ref_on), 32'(exp_if_on() | exp_rf_on()));
        chk("R11", {ctx, " aux_out"}, 32'(aux_out), 32'(exp_aux()));
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        ser_clk = 1'b0;
        ticks(HALF);
        ser_clk = 1'b1;
        ticks(HALF);
    endtask

    // lead: number of surplus bits sent before the 22-bit word
    task automatic write_word(input logic [3:0] a, input logic [17:0] d,
                              input int lead, input logic [31:0] lead_pat);
        logic [21:0] w;
        w = {d, a};
        ser_en_n = 1'b0;
        ticks(HALF);
        for (int i = lead - 1; i >= 0; i--) shift_bit(lead_pat[i % 32]);
        for (int i = 21; i >= 0; i--) shift_bit(w[i]);
        ser_clk = 1'b0;
        ticks(HALF);
        ser_en_n = 1'b1;
        ticks(8);
        model_commit(a, d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [21:0] junk;
        logic [15:0] keep_if;
        void'($urandom(32'h5EED_1234));
        model_reset();
        lock_lost = 1'b1;
        ticks(5);
        rst = 1'b0;
        ticks(2);
        // R13: reset state
        check_all("R13");

        // R1 / R6: basic words and truncation of narrow dividers
        write_word(4'd5, 18'h0A5C3, 0, 0);
        chk("R1", "IF divider after word", 32'(div_if), 32'h0000A5C3);
        write_word(4'd3, 18'h21357, 0, 0);
        chk("R1", "RF1 divider after word", 32'(div_rf1), 32'h00021357);
        write_word(4'd4, 18'h3FFFF, 0, 0);
        chk("R6", "RF2 top bit dropped", 32'(div_rf2), 32'h0001FFFF);
        chk("R7", "band after RF2 write", 32'(rf2_sel), 32'd1);
        check_all("R1");
        write_word(4'd3, 18'h00101, 0, 0);
        chk("R7", "band after RF1 write", 32'(rf2_sel), 32'd0);

        // R2: leading surplus bits are discarded
        write_word(4'd5, 18'h01234, 7, 32'hFFFF_FFFF);
        chk("R2", "IF divider after 7 surplus bits", 32'(div_if), 32'h00001234);
        write_word(4'd4, 18'h00ABC, 13, 32'h0000_1555);
        chk("R2", "RF2 divider after 13 surplus bits", 32'(div_rf2), 32'h00000ABC);

        // R3: clocks while the enable is high shift nothing
        keep_if = div_if;
        junk = {18'h0BEEF, 4'd5};
        for (int i = 21; i >= 0; i--) shift_bit(junk[i]);
        ser_clk = 1'b0;
        ticks(HALF);
        ser_en_n = 1'b0;
        ticks(2 * HALF);
        ser_en_n = 1'b1;
        ticks(8);
        chk("R3", "IF divider after idle-enable clocks", 32'(div_if), 32'(keep_if));

        // R5 / R9: power bits with auto off
        write_word(4'd2, 18'h00002, 0, 0);
        chk("R5", "IF-only power", 32'({if_on, rf_on}), 32'b10);
        write_word(4'd2, 18'h00001, 0, 0);
        chk("R5", "RF-only power", 32'({if_on, rf_on}), 32'b01);
        write_word(4'd2, 18'h00000, 0, 0);
        chk("R10", "reference off when both off", 32'(ref_on), 32'd0);

        // R4 / R9 / R11: main configuration
        write_word(4'd0, 18'h03028, 0, 0);
        chk("R4", "low-power flag", 32'(if_low_pwr), 32'd1);
        chk("R9", "auto turns both on", 32'({if_on, rf_on}), 32'b11);
        lock_lost = 1'b0;
        ticks(1);
        chk("R11", "aux follows lock low", 32'(aux_out), 32'd0);
        lock_lost = 1'b1;
        ticks(1);
        chk("R11", "aux follows lock high", 32'(aux_out), 32'd1);

        // R8 / R14: pin overrides, port still writable
        pwr_dn_n = 1'b0;
        ticks(1);
        chk("R8", "pin low forces off", 32'({if_on, rf_on, ref_on}), 32'b000);
        write_word(4'd5, 18'h0C0DE, 0, 0);
        chk("R14", "write while powered down", 32'(div_if), 32'h0000C0DE);
        check_all("R14");
        pwr_dn_n = 1'b1;
        ticks(1);
        check_all("R9");

        // R11: other aux codes hold the pin low
        write_word(4'd0, 18'h00000, 0, 0);
        chk("R11", "aux code 00", 32'(aux_out), 32'd0);
        write_word(4'd0, 18'h02000, 0, 0);
        chk("R11", "aux code 10", 32'(aux_out), 32'd0);
        write_word(4'd0, 18'h01000, 0, 0);
        chk("R11", "aux code 01", 32'(aux_out), 32'd0);

        // R12: reserved addresses change nothing
        write_word(4'd1, 18'h3FFFF, 0, 0);
        check_all("R12 addr1");
        write_word(4'd6, 18'h3FFFF, 0, 0);
        check_all("R12 addr6");
        write_word(4'd15, 18'h3FFFF, 0, 0);
        check_all("R12 addr15");

        // random words
        for (int n = 0; n < 60; n++) begin
            logic [3:0]  a;
            logic [17:0] d;
            int          lead;
            a    = 4'($urandom_range(0, 15));
            d    = 18'($urandom);
            lead = int'($urandom_range(0, 6));
            pwr_dn_n  = 1'($urandom);
            lock_lost = 1'($urandom);
            write_word(a, d, lead, $urandom);
            check_all("random");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule